// File: doc/BRIEF.md
# Leveling Calibration Failure Monitor

This debug block sits beside a memory PHY's calibration sequencer. It watches the sequencer's progress flags and, when the write-leveling error flag first goes high, it works out which of the three leveling passes failed. The three passes are the first alignment after memory initialisation, the re-run after output-clock delay calibration, and the final touch-up inside write calibration. It encodes the failing pass as a 2-bit code and holds that code until reset.

At three fixed points in the sequence, the block also freezes the fine and coarse strobe delay taps of every byte group into a separate bank. The three points are leveling completing, write calibration starting and overall calibration completing. A bench or debug host reads the banks back, one byte group at a time, through a combinational select port. Because every group is captured together, nothing has to be steered during calibration itself.

Top module: `lvl_fail_monitor`

## Requirements
- R1: A failure is recorded only on a 0-to-1 change of `lvl_err` between two sampling clocks. A level held high records once. `lvl_err` high at the first clock after reset counts as such a change. The code appears on `fail_stage` one clock after the edge is sampled.
- R2: If the edge is seen while `phy_lock_done` and `strobe_found` are both high and `lvl_done` and `wcal_start` are both low, the code is 01 (initial pass).
- R3: If the edge is seen while `lock`/`strobe` are high, `wcal_done` is low and `wcal_start` is low but `lvl_done` is high, the code is 10 (re-run after output-clock delay calibration). If it is seen while `wcal_start` is high, the code is 11 (final pass), whatever `lvl_done` is.
- R4: An error edge is ignored, leaving the code at 00, if it comes while `phy_lock_done` or `strobe_found` is low, or while `wcal_done` is high. A later edge that qualifies is still recorded.
- R5: Once a nonzero code is recorded, it stays unchanged until reset. Later error edges have no effect.
- R6: Bank 0 captures on a rising edge of `lvl_done`, bank 1 on a rising edge of `wcal_start`, and bank 2 on a rising edge of `cal_complete`. Each bank stores the taps of all groups from the clock at which the edge is sampled. Group g's taps are taken from `fine_taps[g*FINE_W +: FINE_W]` and `coarse_taps[g*COARSE_W +: COARSE_W]`. `bank_valid[k]` goes high one clock later.
- R7: A bank is written only on its first edge. Later edges of the same flag leave its contents and its valid bit unchanged until reset.
- R8: `rd_fine`/`rd_coarse` show, combinationally, the stored taps of group `rd_group` in bank `rd_bank`. They read zero when `rd_bank` is 3, when `rd_group` is at least NUM_GROUPS, or when the bank has not captured.
- R9: When `rst_n` is low at a clock edge, the code returns to 00, all valid bits clear and all stored taps clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phy_lock_done | input | 1 | PHY phase lock stage completed |
| strobe_found | input | 1 | Strobe search stage completed |
| lvl_done | input | 1 | Write leveling completed |
| lvl_err | input | 1 | Write leveling error |
| wcal_start | input | 1 | Write calibration has started |
| wcal_done | input | 1 | Write calibration completed |
| cal_complete | input | 1 | Whole calibration completed |
| fine_taps | input | NUM_GROUPS*FINE_W | Current fine taps, group g at bits g*FINE_W |
| coarse_taps | input | NUM_GROUPS*COARSE_W | Current coarse taps, group g at bits g*COARSE_W |
| rd_bank | input | 2 | Snapshot bank select (0..2) |
| rd_group | input | SEL_W | Byte group select |
| fail_stage | output | 2 | 00 none, 01 initial, 10 post output-clock delay, 11 final |
| bank_valid | output | 3 | Capture flag per bank |
| rd_fine | output | FINE_W | Selected stored fine taps |
| rd_coarse | output | COARSE_W | Selected stored coarse taps |

## Verification
The bench builds the block with NUM_GROUPS = 5, FINE_W = 6 and COARSE_W = 3. This leaves a 3-bit group select with three unused codes, so the zero-on-out-of-range read rule can actually be reached. The default of eight groups fills the select field and would never exercise that rule. Tap values are unequal per group, so a misplaced slice shows up on readback. Randomly toggled flags reach every stage code, the ignored-edge cases and the repeated milestone edges, in varied orders.

// File: rtl/lvl_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the leveling failure monitor.
// Assumes three milestone banks, in the order leveling done,
// write-calibration start, calibration complete.
package lvl_mon_pkg;

    typedef enum logic [1:0] {
        STG_NONE      = 2'b00,
        STG_INITIAL   = 2'b01,
        STG_POST_OCLK = 2'b10,
        STG_FINAL     = 2'b11
    } fail_stage_e;

    localparam int NUM_BANKS  = 3;
    localparam int BANK_SEL_W = 2;
    // Index of each flag in the edge-detector vector
    localparam int IDX_ERR    = 0;
    localparam int IDX_MS0    = 1;
    localparam int NUM_EDGES  = IDX_MS0 + NUM_BANKS;

endpackage

// File: rtl/lvl_edge_det.sv
`timescale 1ns/1ps
// Module: lvl_edge_det
// Flags a rising edge on each bit of a level vector. The previous
// level is registered and cleared by reset, so a bit that is high at
// the first clock after reset counts as a rising edge.
// Assumes the inputs are synchronous to clk.
module lvl_edge_det #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_q;

    // Remember last sampled level of every flag
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Edge pulse: high now, low at the previous sample
    always_comb rise_o = level_i & ~prev_q;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chk
            // R1: a pulse never lasts two consecutive cycles
            p_rise_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[i] |=> !rise_o[i]);
        end
    endgenerate

endmodule

// File: rtl/lvl_stage_decoder.sv
`timescale 1ns/1ps
// Module: lvl_stage_decoder
// Classifies the first qualified rising edge of the leveling error by
// the progress flags sampled in the same cycle, and holds the code.
// Assumes err_rise_i is a one-cycle pulse from lvl_edge_det.
module lvl_stage_decoder
    import lvl_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        err_rise_i,
    input  logic        lock_done_i,
    input  logic        strobe_found_i,
    input  logic        lvl_done_i,
    input  logic        wcal_start_i,
    input  logic        wcal_done_i,
    output fail_stage_e stage_o
);

    fail_stage_e stage_q;
    fail_stage_e stage_next;
    logic        qualified;

    // Edge counts only once the pre-leveling stages are done and
    // write calibration has not already finished
    always_comb qualified = lock_done_i && strobe_found_i && !wcal_done_i;

    // Pick the pass the failure belongs to; later stages win
    always_comb begin
        if (wcal_start_i)    stage_next = STG_FINAL;
        else if (lvl_done_i) stage_next = STG_POST_OCLK;
        else                 stage_next = STG_INITIAL;
    end

    // Record the first qualified failure and keep it until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= STG_NONE;
        else if (err_rise_i && qualified && stage_q == STG_NONE)
            stage_q <= stage_next;
    end

    assign stage_o = stage_q;

    // R9: reset clears the recorded stage
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> stage_o == STG_NONE);

    // R5: a recorded stage never changes before reset
    p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_o != STG_NONE |=> $stable(stage_o));

    // R2: a qualified edge with nothing recorded yields a nonzero code
    p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rise_i && qualified && stage_o == STG_NONE) |=> stage_o != STG_NONE);

    // R4: an unqualified edge leaves the code at none
    p_ignore_unqual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rise_i && !qualified && stage_o == STG_NONE) |=> stage_o == STG_NONE);

    // R3: write calibration already running means the final pass
    p_final_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rise_i && qualified && wcal_start_i && stage_o == STG_NONE)
            |=> stage_o == STG_FINAL);

endmodule

// File: rtl/lvl_snap_bank.sv
`timescale 1ns/1ps
// Module: lvl_snap_bank
// Stores the fine and coarse taps of all byte groups on the first
// capture pulse after reset and then freezes them.
// Assumes capture_i is a one-cycle pulse.
module lvl_snap_bank #(
    parameter int NUM_GROUPS = 8,
    parameter int FINE_W     = 6,
    parameter int COARSE_W   = 3,
    localparam int FINE_TOT   = NUM_GROUPS * FINE_W,
    localparam int COARSE_TOT = NUM_GROUPS * COARSE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_i,
    input  logic [FINE_TOT-1:0]   fine_i,
    input  logic [COARSE_TOT-1:0] coarse_i,
    output logic                  valid_o,
    output logic [FINE_TOT-1:0]   fine_o,
    output logic [COARSE_TOT-1:0] coarse_o
);

    logic                  valid_q;
    logic [FINE_TOT-1:0]   fine_q;
    logic [COARSE_TOT-1:0] coarse_q;

    // Write-once snapshot of every group's taps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (capture_i && !valid_q) begin
            valid_q  <= 1'b1;
            fine_q   <= fine_i;
            coarse_q <= coarse_i;
        end
    end

    assign valid_o  = valid_q;
    assign fine_o   = fine_q;
    assign coarse_o = coarse_q;

    // R6: a capture pulse leaves the bank marked valid
    p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> valid_o);

    // R7: a filled bank stays frozen until reset
    p_bank_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (valid_o && $stable(fine_o) && $stable(coarse_o)));

    // R9: reset empties the bank
    p_bank_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && fine_o == '0 && coarse_o == '0));

endmodule

// File: rtl/lvl_fail_monitor.sv
`timescale 1ns/1ps
// Module: lvl_fail_monitor (top)
// Watches calibration progress flags, records which leveling pass
// failed, and snapshots all byte-group taps at three milestones.
// A combinational port reads one group of one bank.
// Assumes all flags and taps are synchronous to clk.
module lvl_fail_monitor
    import lvl_mon_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int FINE_W     = 6,
    parameter int COARSE_W   = 3,
    localparam int SEL_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int FINE_TOT   = NUM_GROUPS * FINE_W,
    localparam int COARSE_TOT = NUM_GROUPS * COARSE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  phy_lock_done,
    input  logic                  strobe_found,
    input  logic                  lvl_done,
    input  logic                  lvl_err,
    input  logic                  wcal_start,
    input  logic                  wcal_done,
    input  logic                  cal_complete,
    input  logic [FINE_TOT-1:0]   fine_taps,
    input  logic [COARSE_TOT-1:0] coarse_taps,
    input  logic [BANK_SEL_W-1:0] rd_bank,
    input  logic [SEL_W-1:0]      rd_group,
    output logic [1:0]            fail_stage,
    output logic [NUM_BANKS-1:0]  bank_valid,
    output logic [FINE_W-1:0]     rd_fine,
    output logic [COARSE_W-1:0]   rd_coarse
);

    logic [NUM_EDGES-1:0]  flag_level;
    logic [NUM_EDGES-1:0]  flag_rise;
    fail_stage_e           stage;
    logic [FINE_TOT-1:0]   bank_fine   [NUM_BANKS];
    logic [COARSE_TOT-1:0] bank_coarse [NUM_BANKS];

    // Gather the edge-sensitive flags: error first, then milestones
    always_comb flag_level = {cal_complete, wcal_start, lvl_done, lvl_err};

    lvl_edge_det #(.WIDTH(NUM_EDGES)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (flag_level),
        .rise_o  (flag_rise)
    );

    lvl_stage_decoder u_stage (
        .clk            (clk),
        .rst_n          (rst_n),
        .err_rise_i     (flag_rise[IDX_ERR]),
        .lock_done_i    (phy_lock_done),
        .strobe_found_i (strobe_found),
        .lvl_done_i     (lvl_done),
        .wcal_start_i   (wcal_start),
        .wcal_done_i    (wcal_done),
        .stage_o        (stage)
    );

    assign fail_stage = stage;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            lvl_snap_bank #(
                .NUM_GROUPS (NUM_GROUPS),
                .FINE_W     (FINE_W),
                .COARSE_W   (COARSE_W)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture_i (flag_rise[IDX_MS0 + b]),
                .fine_i    (fine_taps),
                .coarse_i  (coarse_taps),
                .valid_o   (bank_valid[b]),
                .fine_o    (bank_fine[b]),
                .coarse_o  (bank_coarse[b])
            );
        end
    endgenerate

    // Read mux: select one group of one bank, zero when out of range
    always_comb begin
        rd_fine   = '0;
        rd_coarse = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (rd_bank == BANK_SEL_W'(b) && rd_group == SEL_W'(g)) begin
                    rd_fine   = bank_fine[b][g*FINE_W +: FINE_W];
                    rd_coarse = bank_coarse[b][g*COARSE_W +: COARSE_W];
                end
            end
        end
    end

    // R8: unused bank code or group index reads as zero
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_bank) >= NUM_BANKS || int'(rd_group) >= NUM_GROUPS)
            |-> (rd_fine == '0 && rd_coarse == '0));

    // R8: a bank that has not captured reads as zero
    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_bank) < NUM_BANKS && !bank_valid[rd_bank])
            |-> (rd_fine == '0 && rd_coarse == '0));

endmodule

// File: tb/lvl_fail_monitor_bench.sv
`timescale 1ns/1ps
module lvl_fail_monitor_bench;

    localparam int NG = 5;
    localparam int FW = 6;
    localparam int CW = 3;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           phy_lock_done = 0, strobe_found = 0, lvl_done = 0, lvl_err = 0;
    logic           wcal_start = 0, wcal_done = 0, cal_complete = 0;
    logic [NG*FW-1:0] fine_taps = '0;
    logic [NG*CW-1:0] coarse_taps = '0;
    logic [1:0]     rd_bank = '0;
    logic [SW-1:0]  rd_group = '0;
    logic [1:0]     fail_stage;
    logic [2:0]     bank_valid;
    logic [FW-1:0]  rd_fine;
    logic [CW-1:0]  rd_coarse;

    lvl_fail_monitor #(.NUM_GROUPS(NG), .FINE_W(FW), .COARSE_W(CW)) u_lvl_fail_monitor (
        .clk(clk), .rst_n(rst_n), .phy_lock_done(phy_lock_done), .strobe_found(strobe_found),
        .lvl_done(lvl_done), .lvl_err(lvl_err), .wcal_start(wcal_start), .wcal_done(wcal_done),
        .cal_complete(cal_complete), .fine_taps(fine_taps), .coarse_taps(coarse_taps),
        .rd_bank(rd_bank), .rd_group(rd_group), .fail_stage(fail_stage),
        .bank_valid(bank_valid), .rd_fine(rd_fine), .rd_coarse(rd_coarse)
    );

    int vectors = 0;
    int miscompares = 0;

    // Reference state built from the requirements
    logic [1:0]    m_stage;
    logic [2:0]    m_valid;
    logic [FW-1:0] m_fine   [3][NG];
    logic [CW-1:0] m_coarse [3][NG];
    logic [3:0]    m_prev;

    // R2/R3/R4: expected code for a rising error edge
    function automatic logic [1:0] exp_code(input logic lk, input logic sf,
                                            input logic ld, input logic ws, input logic wd);
        if (!(lk && sf) || wd) return 2'b00;
        if (ws) return 2'b11;
        if (ld) return 2'b10;
        return 2'b01;
    endfunction

    task automatic model_clear();
        m_stage = 2'b00; m_valid = 3'b000; m_prev = 4'b0000;
        for (int b = 0; b < 3; b++)
            for (int g = 0; g < NG; g++) begin
                m_fine[b][g] = '0; m_coarse[b][g] = '0;
            end
    endtask

    task automatic model_update();
        logic [3:0] cur;
        logic [3:0] rise;
        if (!rst_n) begin
            model_clear();
            return;
        end
        cur  = {cal_complete, wcal_start, lvl_done, lvl_err};
        rise = cur & ~m_prev;
        if (rise[0] && m_stage == 2'b00)
            m_stage = exp_code(phy_lock_done, strobe_found, lvl_done, wcal_start, wcal_done);
        for (int b = 0; b < 3; b++)
            if (rise[b+1] && !m_valid[b]) begin
                m_valid[b] = 1'b1;
                for (int g = 0; g < NG; g++) begin
                    m_fine[b][g]   = fine_taps[g*FW +: FW];
                    m_coarse[b][g] = coarse_taps[g*CW +: CW];
                end
            end
        m_prev = cur;
    endtask

    // One clock: update model at the edge, settle past the falling edge
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        #0.5;
    endtask

    task automatic check_val(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_status(input string req);
        check_val({req, " stage"}, int'(fail_stage), int'(m_stage));
        check_val({req, " valid"}, int'(bank_valid), int'(m_valid));
    endtask

    // R8: one combinational read compared with the reference
    task automatic check_read(input int b, input int g, input string req);
        int ef, ec;
        rd_bank  = 2'(b);
        rd_group = SW'(g);
        #0.05;
        ef = 0; ec = 0;
        if (b < 3 && g < NG) begin
            ef = int'(m_fine[b][g]); ec = int'(m_coarse[b][g]);
        end
        check_val({req, " rd_fine"}, int'(rd_fine), ef);
        check_val({req, " rd_coarse"}, int'(rd_coarse), ec);
    endtask

    task automatic sweep(input string req);
        for (int b = 0; b < 4; b++)
            for (int g = 0; g < (1 << SW); g++)
                check_read(b, g, req);
    endtask

    task automatic rand_taps();
        fine_taps   = (NG*FW)'({$urandom, $urandom});
        coarse_taps = (NG*CW)'($urandom);
    endtask

    task automatic flags(input logic lk, input logic sf, input logic ld, input logic le,
                         input logic ws, input logic wd, input logic cc);
        phy_lock_done = lk; strobe_found = sf; lvl_done = ld; lvl_err = le;
        wcal_start = ws; wcal_done = wd; cal_complete = cc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    bit finished = 0;

    initial begin
        void'($urandom(32'd20240611));
        model_clear();

        // R9: reset state
        flags(0,0,0,0,0,0,0);
        rand_taps();
        do_reset();
        check_val("R9 reset stage", int'(fail_stage), 0);
        check_val("R9 reset valid", int'(bank_valid), 0);
        sweep("R9 reset read");

        // R2 initial pass, then R5 hold against later edges
        flags(1,1,0,0,0,0,0); step();
        flags(1,1,0,1,0,0,0); step();
        check_val("R2 initial code", int'(fail_stage), 1);
        step();
        check_val("R1 level held", int'(fail_stage), 1);
        flags(1,1,1,0,1,0,0); step();
        flags(1,1,1,1,1,0,0); step();
        check_val("R5 code held", int'(fail_stage), 1);
        check_status("R6 banks");
        sweep("R6 banks after capture");

        // R3 post output-clock code, R6/R7 bank 0 write once
        do_reset();
        rand_taps();
        flags(1,1,1,0,0,0,0); step();
        check_val("R6 bank0 valid", int'(bank_valid), 1);
        sweep("R6 bank0 contents");
        flags(1,1,0,0,0,0,0); step();
        rand_taps();
        flags(1,1,1,0,0,0,0); step();
        sweep("R7 bank0 unchanged");
        flags(1,1,1,1,0,0,0); step();
        check_val("R3 post-oclk code", int'(fail_stage), 2);

        // R3 final pass code, banks 1 and 2
        do_reset();
        flags(1,1,1,0,0,0,0); step();
        rand_taps();
        flags(1,1,1,0,1,0,0); step();
        flags(1,1,1,1,1,0,0); step();
        check_val("R3 final code", int'(fail_stage), 3);
        rand_taps();
        flags(1,1,1,1,1,1,1); step();
        check_val("R6 bank2 valid", int'(bank_valid), 7);
        sweep("R6 all banks");

        // R4 unqualified edges are ignored, later qualified one records
        do_reset();
        flags(0,1,0,1,0,0,0); step();
        check_val("R4 no lock", int'(fail_stage), 0);
        flags(1,1,0,1,0,0,0); step();
        check_val("R4 held level no edge", int'(fail_stage), 0);
        flags(1,1,0,0,1,1,0); step();
        flags(1,1,0,1,1,1,0); step();
        check_val("R4 after wcal done", int'(fail_stage), 0);
        flags(1,1,0,0,1,0,0); step();
        flags(1,1,0,1,1,0,0); step();
        check_val("R4 later qualified edge", int'(fail_stage), 3);

        // R1 error already high when reset releases
        rst_n = 1'b0;
        flags(1,1,0,1,0,0,0);
        step(); step();
        rst_n = 1'b1;
        step();
        check_val("R1 edge at reset exit", int'(fail_stage), 1);

        // Random flag walks against the reference
        for (int t = 0; t < 60; t++) begin
            logic [6:0] f;
            do_reset();
            check_status("R9 trial reset");
            f = '0;
            for (int c = 0; c < 40; c++) begin
                for (int k = 0; k < 7; k++)
                    if ($urandom_range(5) == 0) f[k] = ~f[k];
                flags(f[0], f[1], f[2], f[3], f[4], f[5], f[6]);
                rand_taps();
                step();
                check_status("R1 R2 R3 R4 R5 R6 R7 random");
                check_read(int'($urandom_range(3)), int'($urandom_range(7)), "R8 random read");
            end
            sweep("R7 R8 trial sweep");
        end

        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule